// File: doc/BRIEF.md
# Dual-Port Word Memory with Contention Arbiter

This block is a synchronous word memory with two fully independent ports, left and right. Each port has its own address, write data, read data, a pair of chip selects of opposite polarity, an output enable, a read/write strobe and two byte-lane enables. Both ports can read or write any word in the same cycle. When both ports are selected at the same address, an arbiter lets one port keep access and raises a busy flag toward the other port. That port's write is then discarded.

A mode pin chooses the role of the busy flags. In master mode the block arbitrates and drives the flags out. In slave mode the outputs stay low and the per-port busy inputs gate the writes. With this, several devices can sit side by side to widen the data word, one master with the rest as slaves. Arbitration is resolved per clock. A port that was already selected at the contested address in the previous cycle keeps it. When both ports arrive in the same cycle, the left port wins.

Top module: `dpram_arbiter`

## Requirements
- R1: A port is selected only when its ce0_n input is 0 and its ce1 input is 1. A deselected port writes nothing, and its read data holds its last value.
- R2: Both ports can access different words in the same cycle. Writes on both sides take effect, and reads on both sides return the stored words.
- R3: ub_n=0 enables bits [15:8] and lb_n=0 enables bits [7:0]. A write (we_n=0) changes only the enabled lanes. A read (we_n=1, oe_n=0) returns the enabled lanes on the read data at the next clock edge, with the other lanes at zero.
- R4: In master mode (ms_i=1), a busy output rises only while both ports are selected and their addresses are equal.
- R5: When both ports begin accessing the same word in the same cycle, the left port wins. busy_r_o goes high combinationally in that cycle, and busy_l_o stays low.
- R6: If one port was already selected at the contested address in the previous cycle and the other port arrives now, the earlier port wins. The late port sees busy.
- R7: A write from a port whose busy is asserted is ignored. The winning port's write in the same cycle takes effect.
- R8: After the match ends (a port deselects or the addresses differ), busy stays high for exactly one more cycle and then drops. A write from that port during the extra cycle is also ignored.
- R9: In slave mode (ms_i=0), both busy outputs are 0 and no arbitration takes place. A high busy_l_i or busy_r_i blocks that port's writes, but not its reads.
- R10: After reset, both read data outputs and both busy outputs are 0, and every word reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ms_i | input | 1 | 1 = master (arbitrate, drive busy), 0 = slave (busy is an input) |
| l_ce0_n_i | input | 1 | Left chip select, active low |
| l_ce1_i | input | 1 | Left chip select, active high |
| l_oe_n_i | input | 1 | Left output enable, active low |
| l_we_n_i | input | 1 | Left strobe: 0 = write, 1 = read |
| l_ub_n_i | input | 1 | Left upper lane enable, active low |
| l_lb_n_i | input | 1 | Left lower lane enable, active low |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | 2*BYTE_W | Left write data |
| l_rdata_o | output | 2*BYTE_W | Left read data, registered |
| busy_l_i | input | 1 | Left busy input (slave mode) |
| busy_l_o | output | 1 | Left busy output (master mode) |
| r_ce0_n_i | input | 1 | Right chip select, active low |
| r_ce1_i | input | 1 | Right chip select, active high |
| r_oe_n_i | input | 1 | Right output enable, active low |
| r_we_n_i | input | 1 | Right strobe: 0 = write, 1 = read |
| r_ub_n_i | input | 1 | Right upper lane enable, active low |
| r_lb_n_i | input | 1 | Right lower lane enable, active low |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | 2*BYTE_W | Right write data |
| r_rdata_o | output | 2*BYTE_W | Right read data, registered |
| busy_r_i | input | 1 | Right busy input (slave mode) |
| busy_r_o | output | 1 | Right busy output (master mode) |

## Verification
The bench targets these corner cases:

- **Same-cycle tie.** An arbiter that broke the tie the wrong way, or flagged both ports, would let the right port's data land in the word or block both writes.
- **Late arrival on a held word.** A design that ignored arrival order would hand the word to the left port and overwrite the right port's data.
- **The extra busy cycle after the match ends.** A release that came too early or too late would show up at the busy output.
- **Slave mode.** The bench checks that the busy outputs stay quiet and that a busy input blocks only writes.
- **Byte lanes and chip selects.** The bench drives single-lane writes and reads, and both half-selected chip-select states. Lane-mixing errors or a wrong chip-select polarity would corrupt the read-back words.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec (
  input  logic       ce0_n_i,
  input  logic       ce1_i,
  input  logic       oe_n_i,
  input  logic       we_n_i,
  input  logic       ub_n_i,
  input  logic       lb_n_i,
  input  logic       block_i,
  output logic       sel_o,
  output logic [1:0] wr_be_o,
  output logic [1:0] rd_be_o
);
  logic [1:0] lane;

  assign sel_o   = ~ce0_n_i & ce1_i;
  assign lane    = {~ub_n_i, ~lb_n_i};
  assign wr_be_o = (sel_o & ~we_n_i & ~block_i) ? lane : 2'b00;
  assign rd_be_o = (sel_o & we_n_i & ~oe_n_i) ? lane : 2'b00;
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_i,
  input  logic              sel_l_i,
  input  logic              sel_r_i,
  input  logic [ADDR_W-1:0] addr_l_i,
  input  logic [ADDR_W-1:0] addr_r_i,
  output logic              lost_l_o,
  output logic              lost_r_o
);
  logic              match, match_q;
  logic              sel_l_q, sel_r_q;
  logic [ADDR_W-1:0] addr_l_q, addr_r_q;
  logic              l_old, r_old;
  owner_e            owner_q, winner, fresh;

  assign match = sel_l_i & sel_r_i & (addr_l_i == addr_r_i);
  // a port that already sat on this word last cycle came first
  assign l_old = sel_l_q & (addr_l_q == addr_l_i);
  assign r_old = sel_r_q & (addr_r_q == addr_r_i);
  assign fresh = (r_old & ~l_old) ? OWN_RIGHT : OWN_LEFT;

  always_comb begin
    winner = OWN_NONE;
    if (match) winner = (owner_q != OWN_NONE) ? owner_q : fresh;
  end

  // loser flag: current contention or one trailing cycle after it
  assign lost_l_o = (winner == OWN_RIGHT) | (owner_q == OWN_RIGHT);
  assign lost_r_o = (winner == OWN_LEFT)  | (owner_q == OWN_LEFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      match_q  <= 1'b0;
      sel_l_q  <= 1'b0;
      sel_r_q  <= 1'b0;
      addr_l_q <= '0;
      addr_r_q <= '0;
    end else begin
      owner_q  <= winner;
      match_q  <= match;
      sel_l_q  <= sel_l_i;
      sel_r_q  <= sel_r_i;
      addr_l_q <= addr_l_i;
      addr_r_q <= addr_r_i;
    end
  end

  p_busy_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lost_l_o && lost_r_o));
  p_busy_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_i && !match && !match_q) |-> (!lost_l_o && !lost_r_o));
endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_l_i,
  input  logic [2*BYTE_W-1:0] wdata_l_i,
  input  logic [1:0]          wr_be_l_i,
  input  logic [1:0]          rd_be_l_i,
  output logic [2*BYTE_W-1:0] rdata_l_o,
  input  logic [ADDR_W-1:0]   addr_r_i,
  input  logic [2*BYTE_W-1:0] wdata_r_i,
  input  logic [1:0]          wr_be_r_i,
  input  logic [1:0]          rd_be_r_i,
  output logic [2*BYTE_W-1:0] rdata_r_o
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // right first, left last: left prevails if both write one word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (wr_be_r_i[b]) mem[addr_r_i][b*BYTE_W +: BYTE_W] <= wdata_r_i[b*BYTE_W +: BYTE_W];
        if (wr_be_l_i[b]) mem[addr_l_i][b*BYTE_W +: BYTE_W] <= wdata_l_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_l_o[b*BYTE_W +: BYTE_W] <= '0;
        rdata_r_o[b*BYTE_W +: BYTE_W] <= '0;
      end else begin
        if (|rd_be_l_i)
          rdata_l_o[b*BYTE_W +: BYTE_W] <= rd_be_l_i[b] ? mem[addr_l_i][b*BYTE_W +: BYTE_W] : '0;
        if (|rd_be_r_i)
          rdata_r_o[b*BYTE_W +: BYTE_W] <= rd_be_r_i[b] ? mem[addr_r_i][b*BYTE_W +: BYTE_W] : '0;
      end
    end
  end

  p_lane_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rd_be_l_i) && !rd_be_l_i[1]) |=> (rdata_l_o[DATA_W-1:BYTE_W] == '0));
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ms_i,
  input  logic                l_ce0_n_i,
  input  logic                l_ce1_i,
  input  logic                l_oe_n_i,
  input  logic                l_we_n_i,
  input  logic                l_ub_n_i,
  input  logic                l_lb_n_i,
  input  logic [ADDR_W-1:0]   l_addr_i,
  input  logic [2*BYTE_W-1:0] l_wdata_i,
  output logic [2*BYTE_W-1:0] l_rdata_o,
  input  logic                busy_l_i,
  output logic                busy_l_o,
  input  logic                r_ce0_n_i,
  input  logic                r_ce1_i,
  input  logic                r_oe_n_i,
  input  logic                r_we_n_i,
  input  logic                r_ub_n_i,
  input  logic                r_lb_n_i,
  input  logic [ADDR_W-1:0]   r_addr_i,
  input  logic [2*BYTE_W-1:0] r_wdata_i,
  output logic [2*BYTE_W-1:0] r_rdata_o,
  input  logic                busy_r_i,
  output logic                busy_r_o
);
  logic       sel_l, sel_r, lost_l, lost_r, block_l, block_r;
  logic [1:0] wr_be_l, rd_be_l, wr_be_r, rd_be_r;

  assign busy_l_o = ms_i & lost_l;
  assign busy_r_o = ms_i & lost_r;
  assign block_l  = ms_i ? lost_l : busy_l_i;
  assign block_r  = ms_i ? lost_r : busy_r_i;

  dpram_port_dec i_dec_l (
    .ce0_n_i(l_ce0_n_i), .ce1_i(l_ce1_i), .oe_n_i(l_oe_n_i), .we_n_i(l_we_n_i),
    .ub_n_i(l_ub_n_i), .lb_n_i(l_lb_n_i), .block_i(block_l),
    .sel_o(sel_l), .wr_be_o(wr_be_l), .rd_be_o(rd_be_l)
  );

  dpram_port_dec i_dec_r (
    .ce0_n_i(r_ce0_n_i), .ce1_i(r_ce1_i), .oe_n_i(r_oe_n_i), .we_n_i(r_we_n_i),
    .ub_n_i(r_ub_n_i), .lb_n_i(r_lb_n_i), .block_i(block_r),
    .sel_o(sel_r), .wr_be_o(wr_be_r), .rd_be_o(rd_be_r)
  );

  dpram_arb #(.ADDR_W(ADDR_W)) i_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .ms_i(ms_i),
    .sel_l_i(sel_l), .sel_r_i(sel_r), .addr_l_i(l_addr_i), .addr_r_i(r_addr_i),
    .lost_l_o(lost_l), .lost_r_o(lost_r)
  );

  dpram_core #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_l_i(l_addr_i), .wdata_l_i(l_wdata_i), .wr_be_l_i(wr_be_l),
    .rd_be_l_i(rd_be_l), .rdata_l_o(l_rdata_o),
    .addr_r_i(r_addr_i), .wdata_r_i(r_wdata_i), .wr_be_r_i(wr_be_r),
    .rd_be_r_i(rd_be_r), .rdata_r_o(r_rdata_o)
  );

  p_busy_rise_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_l_o) || $rose(busy_r_o)) |->
      (!l_ce0_n_i && l_ce1_i && !r_ce0_n_i && r_ce1_i && (l_addr_i == r_addr_i)));
  p_slave_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ms_i |-> (!busy_l_o && !busy_r_o));
endmodule

// File: tb/test_dpram_arbiter.sv
`timescale 1ns/1ps
module test_dpram_arbiter;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, ms = 1'b1;
  logic l_ce0_n, l_ce1, l_oe_n, l_we_n, l_ub_n, l_lb_n, l_bi;
  logic r_ce0_n, r_ce1, r_oe_n, r_we_n, r_ub_n, r_lb_n, r_bi;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd, l_rd, r_rd;
  logic l_bo, r_bo;
  int checks = 0, errors = 0;
  logic [DW-1:0] v;

  always #2.5 clk = ~clk;

  dpram_arbiter #(.ADDR_W(AW), .BYTE_W(8)) i_dpram_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .ms_i(ms),
    .l_ce0_n_i(l_ce0_n), .l_ce1_i(l_ce1), .l_oe_n_i(l_oe_n), .l_we_n_i(l_we_n),
    .l_ub_n_i(l_ub_n), .l_lb_n_i(l_lb_n), .l_addr_i(l_addr), .l_wdata_i(l_wd),
    .l_rdata_o(l_rd), .busy_l_i(l_bi), .busy_l_o(l_bo),
    .r_ce0_n_i(r_ce0_n), .r_ce1_i(r_ce1), .r_oe_n_i(r_oe_n), .r_we_n_i(r_we_n),
    .r_ub_n_i(r_ub_n), .r_lb_n_i(r_lb_n), .r_addr_i(r_addr), .r_wdata_i(r_wd),
    .r_rdata_o(r_rd), .busy_r_i(r_bi), .busy_r_o(r_bo)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode: 0 idle, 1 write, 2 read
  task automatic pl(input int mode, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic ub_n = 1'b0, input logic lb_n = 1'b0);
    l_ce0_n = (mode == 0); l_ce1 = (mode != 0); l_we_n = (mode != 1);
    l_oe_n = (mode != 2); l_ub_n = ub_n; l_lb_n = lb_n; l_addr = a; l_wd = d;
  endtask

  task automatic pr(input int mode, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic ub_n = 1'b0, input logic lb_n = 1'b0);
    r_ce0_n = (mode == 0); r_ce1 = (mode != 0); r_we_n = (mode != 1);
    r_oe_n = (mode != 2); r_ub_n = ub_n; r_lb_n = lb_n; r_addr = a; r_wd = d;
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle;
    pl(0, '0, '0); pr(0, '0, '0); step();
  endtask

  task automatic read_l(input logic [AW-1:0] a, output logic [DW-1:0] d);
    pl(2, a, '0); pr(0, '0, '0); step(); d = l_rd; pl(0, '0, '0);
  endtask

  task automatic t_reset;
    chk("R10 busy_l", {15'd0, l_bo}, 16'd0);
    chk("R10 busy_r", {15'd0, r_bo}, 16'd0);
    chk("R10 rdata_l", l_rd, 16'd0);
    chk("R10 rdata_r", r_rd, 16'd0);
    read_l(6'd63, v); chk("R10 word", v, 16'd0);
  endtask

  task automatic t_deselect;
    pl(1, 6'd20, 16'hDEAD); l_ce0_n = 1'b1; step();
    pl(1, 6'd20, 16'hBEEF); l_ce1 = 1'b0; step();
    read_l(6'd20, v); chk("R1 half-selected writes", v, 16'd0);
    pl(1, 6'd21, 16'h5A5A); step();
    read_l(6'd21, v);
    pl(2, 6'd20, '0); l_ce0_n = 1'b1; step();
    chk("R1 rdata holds", l_rd, 16'h5A5A);
  endtask

  task automatic t_bytes;
    pl(1, 6'd30, 16'hAAAA); step();
    pl(1, 6'd30, 16'h12FF, 1'b0, 1'b1); step();
    read_l(6'd30, v); chk("R3 upper lane", v, 16'h12AA);
    pl(1, 6'd30, 16'hFF34, 1'b1, 1'b0); step();
    read_l(6'd30, v); chk("R3 lower lane", v, 16'h1234);
    pl(2, 6'd30, '0, 1'b0, 1'b1); step();
    chk("R3 read upper only", l_rd, 16'h1200);
    pl(2, 6'd30, '0, 1'b1, 1'b0); step();
    chk("R3 read lower only", l_rd, 16'h0034);
    idle();
  endtask

  task automatic t_dual;
    pl(1, 6'd40, 16'h1111); pr(1, 6'd41, 16'h2222); #1;
    chk("R4 no busy on differing addr", {14'd0, l_bo, r_bo}, 16'd0);
    step();
    pl(2, 6'd41, '0); pr(2, 6'd40, '0); step();
    chk("R2 left reads right write", l_rd, 16'h2222);
    chk("R2 right reads left write", r_rd, 16'h1111);
    pl(1, 6'd41, 16'h3333); pr(1, 6'd41, 16'h4444); r_ce1 = 1'b0; #1;
    chk("R4 no busy when right half-selected", {14'd0, l_bo, r_bo}, 16'd0);
    step(); idle();
  endtask

  task automatic t_tie;
    pl(1, 6'd5, 16'hA5A5); pr(1, 6'd5, 16'h5A5A); #1;
    chk("R5 busy_r on tie", {15'd0, r_bo}, 16'd1);
    chk("R5 busy_l low on tie", {15'd0, l_bo}, 16'd0);
    step();
    pl(0, '0, '0); pr(1, 6'd6, 16'h7777); #1;
    chk("R8 busy_r trails one cycle", {15'd0, r_bo}, 16'd1);
    step();
    pr(0, '0, '0); #1;
    chk("R8 busy_r released", {15'd0, r_bo}, 16'd0);
    step();
    read_l(6'd5, v); chk("R7 winner write kept", v, 16'hA5A5);
    read_l(6'd6, v); chk("R8 write in trailing cycle ignored", v, 16'd0);
  endtask

  task automatic t_arrival;
    pl(0, '0, '0); pr(2, 6'd9, '0); step();
    pl(1, 6'd9, 16'hCCCC); pr(1, 6'd9, 16'hDDDD); #1;
    chk("R6 late left sees busy", {15'd0, l_bo}, 16'd1);
    chk("R6 early right no busy", {15'd0, r_bo}, 16'd0);
    step();
    pl(1, 6'd9, 16'hEEEE); #1;
    chk("R6 ownership held", {15'd0, l_bo}, 16'd1);
    step(); idle(); idle();
    read_l(6'd9, v); chk("R7 loser write ignored", v, 16'hDDDD);
  endtask

  task automatic t_slave;
    ms = 1'b0; l_bi = 1'b1; r_bi = 1'b0;
    pl(1, 6'd12, 16'h0F0F); pr(1, 6'd12, 16'hF0F0); #1;
    chk("R9 slave busy outputs low", {14'd0, l_bo, r_bo}, 16'd0);
    step();
    pl(2, 6'd12, '0); pr(0, '0, '0); step();
    chk("R9 busy_l_i blocks left, right writes", l_rd, 16'hF0F0);
    l_bi = 1'b0; r_bi = 1'b1;
    pl(2, 6'd12, '0); pr(1, 6'd12, 16'h1234); step();
    pl(2, 6'd12, '0); pr(0, '0, '0); step();
    chk("R9 busy_r_i blocks right write", l_rd, 16'hF0F0);
    pr(2, 6'd12, '0); pl(0, '0, '0); step();
    chk("R9 read allowed under busy input", r_rd, 16'hF0F0);
    r_bi = 1'b0; ms = 1'b1; idle();
  endtask

  initial begin
    l_bi = 1'b0; r_bi = 1'b0;
    pl(0, '0, '0); pr(0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deselect();
    t_bytes();
    t_dual();
    t_tie();
    t_arrival();
    t_slave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule